// File: doc/BRIEF.md
# Interrupt-Triggered Chained Descriptor DMA

This engine services a hardware request line in place of the processor. A request carries a 3-bit priority level and a vector number. Only requests at the top level (3'b111) are taken; they are queued and served one at a time. For each request the engine reads a 32-bit entry from a vector table in memory. The low half of that entry is the byte address of a 12-byte descriptor. The engine fetches the whole descriptor and moves 8-bit or 16-bit units from source to destination. It then writes the updated count and addresses back into the same descriptor, so the descriptor always holds the live transfer state.

Chaining is done by rewriting the vector table entry. When a transfer's count reaches zero and its chain bit is set, the engine copies the descriptor's 32-bit chain address over the vector entry of the source that triggered it. The next request on that source then runs a different descriptor. All memory traffic goes through one 16-bit synchronous port with byte enables. Read data returns one cycle after the request.

The controller has eight states. It leaves IDLE for VEC when the queue is not empty. VEC reads the two vector words and then goes to DESC. DESC reads six descriptor words. From DESC it goes to DONE if COUNT is zero, to SRC for memory data, and to DST for immediate data. SRC reads one source unit and goes to DST. DST writes one unit. From DST it loops back to SRC or DST in burst mode while COUNT is not zero, and otherwise goes to WB. WB writes back three words. From WB it goes to CHAIN if COUNT is zero and chaining is on, and to DONE otherwise. CHAIN writes the two vector words and goes to DONE. DONE pulses `done` and returns to IDLE.

Top module: `chain_dma`

## Requirements
- R1: A request whose level is not 3'b111 is dropped: it causes no memory access and no `done` pulse.
- R2: Vector entry n is the pair of 16-bit words at `vtab_base + 4*n` (low word) and `+2` (high word), read low word first. The low word is the descriptor's byte base address.
- R3: Descriptor words at byte offsets from the base: +0 mode, +2 COUNT, +4 source, +6 destination, +8 chain address low, +10 chain address high. Mode bits: 0 unit size (1 = 16-bit), 1 data kind (1 = read from memory, 0 = immediate), 2 source increments, 3 destination increments, 5 burst, 7 chain. The other mode bits have no effect.
- R4: Each unit moved decrements COUNT by one. An address with its increment bit set advances by 1 for 8-bit units and by 2 for 16-bit units.
- R5: Memory is little-endian: the byte at an even address is bits 7..0 of its word. An 8-bit unit reads the byte at the source address and writes only the byte lane of the destination address.
- R6: For immediate data, the low byte or word of the source field itself is written, and no source read is issued.
- R7: In single mode each request moves exactly one unit.
- R8: In burst mode a request moves units until COUNT is zero.
- R9: COUNT, source and destination are written back to the descriptor before `done`. `done` is a one-cycle pulse per request.
- R10: When COUNT becomes zero and the chain bit is set, the vector entry is overwritten with the chain address (low, high), and the next request uses the new descriptor.
- R11: A descriptor fetched with COUNT zero moves no data, writes nothing, leaves the vector entry unchanged, and still pulses `done`.
- R12: Requests that arrive while the engine is busy are held, up to the queue depth, and served in arrival order.
- R13: After reset `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vtab_base | input | 16 | Byte base address of the vector table |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_level | input | 3 | Priority level of the request |
| req_vec | input | 6 | Vector number of the requesting source |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address; bit 0 is ignored by the memory |
| mem_be | output | 2 | Byte enables for a write (bit 0 = low byte) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read |
| busy | output | 1 | Engine is serving a request |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions check on every cycle that:
- a request at a lower level never enters the queue;
- each destination write lowers COUNT by exactly one;
- single mode goes straight from the write to write-back;
- no source read occurs for immediate data;
- the vector is rewritten only at COUNT zero with chaining on;
- `done` lasts one cycle;
- the queue never pops while empty.

Only the bench scenarios can show end-to-end results. These are the byte lanes and little-endian ordering, the address stepping, and what lands in the write-back and the chain-rewritten vector. They also include the effect of a chain switch on the following request and the arrival order of queued requests. The bench compares the entire memory image against its own model after every request.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
    localparam int DW = 16;
    localparam logic [2:0] DMA_LEVEL = 3'b111;

    localparam int M_SIZE  = 0;
    localparam int M_MEM   = 1;
    localparam int M_SINC  = 2;
    localparam int M_DINC  = 3;
    localparam int M_BURST = 5;
    localparam int M_CHAIN = 7;

    localparam int VEC_WORDS  = 2;
    localparam int DESC_WORDS = 6;
    localparam int WB_WORDS   = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_VEC, ST_DESC, ST_SRC, ST_DST, ST_WB, ST_CHAIN, ST_DONE
    } dma_state_e;
endpackage

// File: rtl/cdma_req_queue.sv
module cdma_req_queue #(
    parameter int W     = 6,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] slot [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   fill;
    logic          push_ok;

    assign push_ok = push && !full;
    assign empty   = (fill == '0);
    assign full    = (fill == (PW+1)'(DEPTH));
    assign dout    = slot[rp];

    always_ff @(posedge clk) begin
        if (push_ok) slot[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push_ok) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop)     rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            fill <= fill + (PW+1)'(push_ok) - (PW+1)'(pop);
        end
    end

    a_r12_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r12_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (PW+1)'(DEPTH));
endmodule

// File: rtl/cdma_lane.sv
module cdma_lane #(
    parameter int DW = 16
) (
    input  logic          wide,
    input  logic [DW-1:0] rword,
    input  logic          rsel,
    output logic [DW-1:0] runit,
    input  logic [DW-1:0] unit,
    input  logic          wsel,
    output logic [DW-1:0] wword,
    output logic [1:0]    wbe
);
    localparam int HB = DW / 2;

    always_comb begin
        if (wide) begin
            runit = rword;
            wword = unit;
            wbe   = 2'b11;
        end else begin
            runit = {{HB{1'b0}}, (rsel ? rword[DW-1:HB] : rword[HB-1:0])};
            wword = {unit[HB-1:0], unit[HB-1:0]};
            wbe   = wsel ? 2'b10 : 2'b01;
        end
    end
endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int VEC_W  = 6,
    parameter int QDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    vtab_base,
    input  logic             req_valid,
    input  logic [2:0]       req_level,
    input  logic [VEC_W-1:0] req_vec,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [1:0]       mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             done
);
    dma_state_e st, st_nx;
    logic       ph;
    logic [2:0] idx;

    logic [VEC_W-1:0] cur_vec, q_head;
    logic q_empty, q_full, q_push, q_pop;

    logic [DW-1:0] desc_base, cnt, sadr, dadr, link_lo, link_hi, unit_q;
    logic m_size, m_mem, m_sinc, m_dinc, m_burst, m_chain;
    logic [DW-1:0] rd_unit, wr_word, vec_addr, off, step, cnt_dec;
    logic [1:0]    wr_be;
    logic          is_read;

    assign q_push   = req_valid && (req_level == DMA_LEVEL);
    assign q_pop    = (st == ST_IDLE) && !q_empty;
    assign vec_addr = vtab_base + DW'({cur_vec, 2'b00});
    assign off      = DW'({idx, 1'b0});
    assign step     = m_size ? DW'(2) : DW'(1);
    assign cnt_dec  = cnt - DW'(1);
    assign is_read  = (st == ST_VEC) || (st == ST_DESC) || (st == ST_SRC);

    cdma_req_queue #(.W(VEC_W), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(req_vec),
        .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full)
    );

    cdma_lane #(.DW(DW)) u_lane (
        .wide(m_size), .rword(mem_rdata), .rsel(sadr[0]), .runit(rd_unit),
        .unit(m_mem ? unit_q : sadr), .wsel(dadr[0]),
        .wword(wr_word), .wbe(wr_be)
    );

    // next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (!q_empty) st_nx = ST_VEC;
            ST_VEC:   if (ph && idx == 3'(VEC_WORDS-1)) st_nx = ST_DESC;
            ST_DESC:  if (ph && idx == 3'(DESC_WORDS-1))
                          st_nx = (cnt == '0) ? ST_DONE : (m_mem ? ST_SRC : ST_DST);
            ST_SRC:   if (ph) st_nx = ST_DST;
            ST_DST:   if (m_burst && cnt_dec != '0) st_nx = m_mem ? ST_SRC : ST_DST;
                      else st_nx = ST_WB;
            ST_WB:    if (idx == 3'(WB_WORDS-1))
                          st_nx = (cnt == '0 && m_chain) ? ST_CHAIN : ST_DONE;
            ST_CHAIN: if (idx == 3'(VEC_WORDS-1)) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // sequencing counters and descriptor datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 1'b0; idx <= '0; cur_vec <= '0;
            desc_base <= '0; cnt <= '0; sadr <= '0; dadr <= '0;
            link_lo <= '0; link_hi <= '0; unit_q <= '0;
            m_size <= 1'b0; m_mem <= 1'b0; m_sinc <= 1'b0;
            m_dinc <= 1'b0; m_burst <= 1'b0; m_chain <= 1'b0;
        end else begin
            if (st_nx != st) begin
                ph  <= 1'b0;
                idx <= '0;
            end else if (is_read) begin
                ph <= ~ph;
                if (ph) idx <= idx + 3'd1;
            end else begin
                idx <= idx + 3'd1;
            end

            if (q_pop) cur_vec <= q_head;

            if (st == ST_VEC && ph && idx == 3'd0) desc_base <= mem_rdata;

            if (st == ST_DESC && ph) begin
                case (idx)
                    3'd0: begin
                        m_size  <= mem_rdata[M_SIZE];
                        m_mem   <= mem_rdata[M_MEM];
                        m_sinc  <= mem_rdata[M_SINC];
                        m_dinc  <= mem_rdata[M_DINC];
                        m_burst <= mem_rdata[M_BURST];
                        m_chain <= mem_rdata[M_CHAIN];
                    end
                    3'd1:    cnt     <= mem_rdata;
                    3'd2:    sadr    <= mem_rdata;
                    3'd3:    dadr    <= mem_rdata;
                    3'd4:    link_lo <= mem_rdata;
                    default: link_hi <= mem_rdata;
                endcase
            end

            if (st == ST_SRC && ph) unit_q <= rd_unit;

            if (st == ST_DST) begin
                cnt <= cnt_dec;
                if (m_sinc) sadr <= sadr + step;
                if (m_dinc) dadr <= dadr + step;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = 2'b11;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_VEC: begin
                mem_req  = !ph;
                mem_addr = vec_addr + off;
            end
            ST_DESC: begin
                mem_req  = !ph;
                mem_addr = desc_base + off;
            end
            ST_SRC: begin
                mem_req  = !ph;
                mem_addr = {sadr[DW-1:1], 1'b0};
            end
            ST_DST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {dadr[DW-1:1], 1'b0};
                mem_be    = wr_be;
                mem_wdata = wr_word;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_base + DW'(2) + off;
                mem_wdata = (idx == 3'd0) ? cnt : ((idx == 3'd1) ? sadr : dadr);
            end
            ST_CHAIN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = vec_addr + off;
                mem_wdata = (idx == 3'd0) ? link_lo : link_hi;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    assign busy = (st != ST_IDLE);

    a_r1_level_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && q_empty && req_valid && req_level != DMA_LEVEL) |=> q_empty);
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DST) |=> (cnt == $past(cnt) - DW'(1)));
    a_r7_single_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DST && !m_burst) |=> (st == ST_WB));
    a_r6_no_src_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SRC) |-> m_mem);
    a_r10_chain_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHAIN) |-> (cnt == '0 && m_chain));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/chain_dma_test.sv
module chain_dma_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] VBASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_level = 3'd0;
    logic [5:0]  req_vec = '0;
    logic        mem_req, mem_we, busy, done;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  mem_be;

    logic [15:0] mem [0:4095];
    logic [15:0] sm  [0:4095];

    int nchk = 0, nerr = 0, dn = 0, rd_cnt = 0, wr_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_dma uut (
        .clk(clk), .rst_n(rst_n), .vtab_base(VBASE),
        .req_valid(req_valid), .req_level(req_level), .req_vec(req_vec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_be[0]) mem[mem_addr[12:1]][7:0]  <= mem_wdata[7:0];
                if (mem_be[1]) mem[mem_addr[12:1]][15:8] <= mem_wdata[15:8];
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[12:1]];
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (rst_n && done) dn <= dn + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model of the requirements, on the shadow image
    function automatic logic [15:0] r16(input logic [15:0] a);
        return sm[a[12:1]];
    endfunction
    function automatic logic [7:0] r8(input logic [15:0] a);
        logic [15:0] w = sm[a[12:1]];
        return a[0] ? w[15:8] : w[7:0];
    endfunction
    task automatic w16(input logic [15:0] a, input logic [15:0] v);
        sm[a[12:1]] = v;
    endtask
    task automatic w8(input logic [15:0] a, input logic [7:0] v);
        if (a[0]) sm[a[12:1]][15:8] = v;
        else      sm[a[12:1]][7:0]  = v;
    endtask

    task automatic model_req(input int v);
        logic [15:0] va, db, md, c, s, d, c0, c1, u, st;
        bit more;
        va = VBASE + 16'(v * 4);
        db = r16(va);
        md = r16(db); c = r16(db + 2); s = r16(db + 4); d = r16(db + 6);
        c0 = r16(db + 8); c1 = r16(db + 10);
        if (c == 16'd0) return;
        st = md[0] ? 16'd2 : 16'd1;
        more = 1'b1;
        while (more) begin
            if (!md[1])     u = s;
            else if (md[0]) u = r16(s);
            else            u = {8'h00, r8(s)};
            if (md[0]) w16(d, u); else w8(d, u[7:0]);
            c = c - 16'd1;
            if (md[2]) s = s + st;
            if (md[3]) d = d + st;
            more = md[5] && (c != 16'd0);
        end
        w16(db + 2, c); w16(db + 4, s); w16(db + 6, d);
        if (c == 16'd0 && md[7]) begin
            w16(va, c0); w16(va + 2, c1);
        end
    endtask

    task automatic put16(input logic [15:0] a, input logic [15:0] v);
        mem[a[12:1]] = v;
        sm[a[12:1]]  = v;
    endtask
    task automatic set_desc(input logic [15:0] b, input logic [15:0] md, input logic [15:0] c,
                            input logic [15:0] s, input logic [15:0] d, input logic [15:0] ln);
        put16(b, md); put16(b + 2, c); put16(b + 4, s); put16(b + 6, d);
        put16(b + 8, ln); put16(b + 10, 16'h0000);
    endtask
    task automatic set_vec(input int v, input logic [15:0] a);
        put16(VBASE + 16'(v * 4), a);
        put16(VBASE + 16'(v * 4) + 2, 16'h0000);
    endtask

    task automatic cmp_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 4096; i++)
            if (bad < 0 && mem[i] !== sm[i]) bad = i;
        if (bad < 0) chk(1'b1, req, "memory image", 0, 0);
        else chk(1'b0, req, $sformatf("memory word at %0h", bad * 2),
                 int'(mem[bad]), int'(sm[bad]));
    endtask

    task automatic fire(input int v, input logic [2:0] lvl);
        @(negedge clk);
        req_valid = 1'b1; req_level = lvl; req_vec = 6'(v);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int target, input string req);
        int t = 0;
        while (dn < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (dn < target) chk(1'b0, req, "done count", dn, target);
    endtask

    task automatic serve(input int v, input string req);
        int target = dn + 1;
        fire(v, 3'b111);
        wait_done(target, req);
        model_req(v);
        @(negedge clk);
        cmp_mem(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int r0, w0, d0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) begin
            mem[i] = (i >= 16'h0400) ? 16'($urandom) : 16'h0000;
            sm[i]  = mem[i];
        end
        for (int k = 0; k < 16; k++) begin
            logic [15:0] md;
            md = {10'h0, 1'($urandom), 1'b0, 4'($urandom)};
            set_desc(16'h0700 + 16'(k * 16), md, 16'($urandom % 6),
                     16'h0800 + {4'h0, 11'($urandom), 1'b0},
                     16'h1800 + {5'h0, 10'($urandom), 1'b0}, 16'h0000);
        end

        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R13", "reset outputs",
            {busy, done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // chained byte transfer: A (count 2, chain) -> B
        set_desc(16'h0400, 16'h0086, 16'd2, 16'h0800, 16'h1001, 16'h0410);
        set_desc(16'h0410, 16'h0006, 16'd2, 16'h0900, 16'h1002, 16'h0400);
        set_vec(5, 16'h0400);
        r0 = rd_cnt; w0 = wr_cnt;
        serve(5, "R2 R5 R7");
        chk(rd_cnt - r0 == 9, "R7", "reads per single memory unit", rd_cnt - r0, 9);
        chk(wr_cnt - w0 == 4, "R7", "writes per single unit", wr_cnt - w0, 4);
        chk(mem[16'h0402 >> 1] == 16'd1, "R4", "count after one unit",
            int'(mem[16'h0402 >> 1]), 1);
        chk(mem[16'h0404 >> 1] == 16'h0801, "R4", "source step by one",
            int'(mem[16'h0404 >> 1]), 16'h0801);
        serve(5, "R10");
        chk(mem[(VBASE + 20) >> 1] == 16'h0410, "R10", "vector rewritten",
            int'(mem[(VBASE + 20) >> 1]), 16'h0410);
        serve(5, "R10 R5");

        // low level ignored
        d0 = dn; r0 = rd_cnt;
        fire(5, 3'b011);
        repeat (30) @(negedge clk);
        chk(dn == d0 && rd_cnt == r0 && !busy, "R1", "activity on low level",
            rd_cnt - r0, 0);
        cmp_mem("R1");

        // zero count, no chain
        set_desc(16'h04A0, 16'h0006, 16'd0, 16'h0800, 16'h1010, 16'h0700);
        set_vec(6, 16'h04A0);
        w0 = wr_cnt;
        serve(6, "R11");
        chk(wr_cnt == w0, "R11", "writes for zero count", wr_cnt - w0, 0);
        chk(mem[(VBASE + 24) >> 1] == 16'h04A0, "R11", "vector unchanged",
            int'(mem[(VBASE + 24) >> 1]), 16'h04A0);

        // immediate 16-bit, destination incrementing
        set_desc(16'h0480, 16'h0009, 16'd3, 16'hBEEF, 16'h1100, 16'h0000);
        set_vec(7, 16'h0480);
        r0 = rd_cnt;
        serve(7, "R6");
        chk(rd_cnt - r0 == 8, "R6", "reads for immediate unit", rd_cnt - r0, 8);
        serve(7, "R6 R4");
        serve(7, "R6 R4");

        // burst 16-bit, both incrementing
        set_desc(16'h0490, 16'h002F, 16'd4, 16'h0A00, 16'h1200, 16'h0000);
        set_vec(8, 16'h0490);
        serve(8, "R8");
        chk(mem[16'h0492 >> 1] == 16'd0, "R9", "count written back",
            int'(mem[16'h0492 >> 1]), 0);
        chk(mem[16'h0496 >> 1] == 16'h1208, "R9", "destination written back",
            int'(mem[16'h0496 >> 1]), 16'h1208);

        // queued requests, same destination, order decides result
        set_desc(16'h04B0, 16'h0006, 16'd1, 16'h0B00, 16'h1300, 16'h0000);
        set_desc(16'h04C0, 16'h0006, 16'd1, 16'h0B11, 16'h1300, 16'h0000);
        set_vec(10, 16'h04B0);
        set_vec(11, 16'h04C0);
        d0 = dn;
        fire(10, 3'b111);
        fire(11, 3'b111);
        wait_done(d0 + 2, "R12");
        model_req(10);
        model_req(11);
        @(negedge clk);
        cmp_mem("R12");
        chk(mem[16'h1300 >> 1][7:0] == r8(16'h0B11), "R12", "last writer byte",
            int'(mem[16'h1300 >> 1][7:0]), int'(r8(16'h0B11)));

        // constrained random descriptors
        for (int i = 0; i < 40; i++) begin
            int v, n;
            logic [15:0] md, b, s, d;
            v  = $urandom % 48;
            b  = 16'h0400 + 16'(v * 16);
            md = {8'h00, 1'($urandom), 1'b0, 1'($urandom), 1'b0, 4'($urandom)};
            s  = 16'h0800 + 16'($urandom % 16'h0600);
            d  = 16'h1000 + 16'($urandom % 16'h0600);
            if (md[0]) begin s[0] = 1'b0; d[0] = 1'b0; end
            set_desc(b, md, 16'($urandom % 6), s, d, 16'h0700 + 16'(($urandom % 16) * 16));
            set_vec(v, b);
            n = 1 + $urandom % 3;
            for (int j = 0; j < n; j++) serve(v, "R3 R4 R5 R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule